// File: doc/BRIEF.md
# Reloading Down-Counter Timer with Toggle Output

This block divides a count source by a programmable ratio. Software writes an 8-bit reload value n; the counter takes that value at once and then moves down by one on every falling edge of the selected count source. After it passes 00 and reaches FF, the next rising edge of the source raises a one-cycle interrupt request. The falling edge after that loads the reload value minus one, so one pass takes n+1 source periods.

The count source is either an internal divided clock or an external event pin. The selected source and the measurement input each go through a two-flop synchronizer into the system clock domain, where edges become single-cycle strobes. In pulse output mode an output flop inverts on every overflow, which gives a square wave with a 50% duty cycle. Its starting level can be preset only while the timer is stopped: stop, preset, load, start. A gate option makes the timer act on edges only while the measurement input is at a chosen level, which measures pulse widths.

The control FSM has four states. HALT: stopped, with the counter frozen. RUN: counting down above FF. WRAP: the counter is at FF and waits for the rising edge. OVF: the overflow has been raised and the FSM waits for the reload edge. The transitions are:
- HALT to WRAP or RUN on start, depending on whether the counter holds FF.
- RUN to WRAP on a counted falling edge at 00.
- WRAP to OVF on a counted rising edge; this transition raises the interrupt.
- WRAP or OVF to RUN on a counted falling edge, or back to WRAP when the reload value is 0.
- Any state to HALT while stop is 1.
- A latch write, from any state, goes to HALT when stopped, and otherwise to WRAP or RUN.

Top module: `reload_timer`

## Requirements
- R1: After reset the counter and the reload latch hold FF, the timer is stopped, tout is 0 and irq is 0.
- R2: A latch write stores latch_data in the reload latch and in the counter in the same cycle, in any state. It wins over a counted edge that arrives in that cycle, and that edge is dropped.
- R3: While stop is 1, source edges change neither the counter nor irq. Clearing stop resumes counting from the held value.
- R4: Each counted falling edge of the selected source lowers the counter by one, through 00 to FF.
- R5: A counted falling edge while the counter holds FF after a pass loads latch minus one. This gives a ratio of n+1; for n=0, every falling edge reloads FF.
- R6: The first counted rising edge after the counter reaches FF produces exactly one irq pulse, one system clock wide, with count reading FF.
- R7: mode encoding: 2'b00 timer (source src_clk), 2'b01 event (source evt_pin), 2'b10 pulse output (source src_clk), 2'b11 behaves as timer. Edges on the pin that is not selected have no effect.
- R8: In pulse output mode (mode 2'b10), the output flop inverts once per irq. In the other modes it holds its level.
- R9: preset_wr loads preset_val into the output flop only while stop is 1. While the timer runs, preset_wr is ignored.
- R10: When out_en is 0, tout reads 0 and the output flop keeps toggling internally. When out_en is set again, tout shows the flop's current level.
- R11: With gate_en at 1, edges are counted only while the synchronized meas_pin equals gate_level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_clk | input | 1 | Internal count source (timer and pulse modes) |
| evt_pin | input | 1 | External event input (event mode) |
| meas_pin | input | 1 | Input whose level gates counting |
| mode | input | 2 | Mode select, encoding as in R7 |
| gate_en | input | 1 | 1 enables level-gated counting |
| gate_level | input | 1 | Level of meas_pin at which counting is allowed |
| stop | input | 1 | 1 halts the timer |
| latch_wr | input | 1 | Write strobe for the reload latch and counter |
| latch_data | input | 8 | Reload value n |
| out_en | input | 1 | Drives the output flop onto tout |
| preset_wr | input | 1 | Write strobe for the output flop's starting level |
| preset_val | input | 1 | Starting level for the output flop |
| count | output | 8 | Current counter value |
| irq | output | 1 | Overflow interrupt request, one-cycle pulse |
| tout | output | 1 | Toggle output |

## Verification
A latch write and a counted falling edge can hit the FSM in the same clock cycle. The write has to win, and the edge has to be lost. The bench provokes this by changing the source pin and then raising latch_wr exactly two clock cycles later. That timing makes latch_wr line up with the falling-edge strobe once the edge has crossed the synchronizer. The scoreboard then expects the counter to hold the written value, not that value minus one. It also expects the next ordinary edge to count down from the written value.

// File: rtl/rt_pkg.sv
package rt_pkg;
    typedef enum logic [1:0] {
        MODE_TIMER = 2'b00,
        MODE_EVENT = 2'b01,
        MODE_PULSE = 2'b10,
        MODE_RSVD  = 2'b11
    } rt_mode_e;

    typedef enum logic [1:0] {
        ST_HALT = 2'b00,
        ST_RUN  = 2'b01,
        ST_WRAP = 2'b10,
        ST_OVF  = 2'b11
    } rt_state_e;
endpackage

// File: rtl/rt_sync.sv
module rt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    generate
        if (STAGES <= 1) begin : g_single
            logic r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r <= 1'b0;
                else        r <= d;
            end
            assign q = r;
        end else begin : g_chain
            logic [STAGES-1:0] sr;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr <= '0;
                else        sr <= {sr[STAGES-2:0], d};
            end
            assign q = sr[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/rt_edge.sv
module rt_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall,
    output logic rise
);
    logic lvl;
    logic prev;

    rt_sync #(.STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin),
        .q     (lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= lvl;
    end

    assign fall = prev & ~lvl;
    assign rise = ~prev & lvl;
endmodule

// File: rtl/rt_counter.sv
module rt_counter
    import rt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fall,
    input  logic         rise,
    input  logic         en,
    input  logic         stop,
    input  logic         latch_wr,
    input  logic [W-1:0] latch_data,
    output logic [W-1:0] cnt_o,
    output logic         irq_o
);
    localparam logic [W-1:0] ALL1 = {W{1'b1}};
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    rt_state_e    state, nxt_state;
    logic [W-1:0] cnt, nxt_cnt;
    logic [W-1:0] latch, nxt_latch;
    logic         ovf_hit;
    logic         fall_ok, rise_ok;

    assign fall_ok = fall & en;
    assign rise_ok = rise & en;

    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        nxt_latch = latch;
        ovf_hit   = 1'b0;
        if (latch_wr) begin
            nxt_latch = latch_data;
            nxt_cnt   = latch_data;
            nxt_state = stop ? ST_HALT : ((latch_data == ALL1) ? ST_WRAP : ST_RUN);
        end else if (stop) begin
            nxt_state = ST_HALT;
        end else begin
            unique case (state)
                ST_HALT: nxt_state = (cnt == ALL1) ? ST_WRAP : ST_RUN;
                ST_RUN: begin
                    if (fall_ok) begin
                        nxt_cnt   = cnt - ONE;
                        nxt_state = (cnt == '0) ? ST_WRAP : ST_RUN;
                    end
                end
                ST_WRAP: begin
                    if (rise_ok) begin
                        nxt_state = ST_OVF;
                        ovf_hit   = 1'b1;
                    end else if (fall_ok) begin
                        nxt_cnt   = latch - ONE;
                        nxt_state = (latch == '0) ? ST_WRAP : ST_RUN;
                    end
                end
                ST_OVF: begin
                    if (fall_ok) begin
                        nxt_cnt   = latch - ONE;
                        nxt_state = (latch == '0) ? ST_WRAP : ST_RUN;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HALT;
            cnt   <= ALL1;
            latch <= ALL1;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
            latch <= nxt_latch;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= ovf_hit;
    end

    assign cnt_o = cnt;

    // R6: request is one cycle wide
    a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    // R6: request only while counter sits at FF
    a_r6_irq_at_ff: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (cnt_o == ALL1));
    // R3: stopped timer holds its count
    a_r3_stop_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !latch_wr) |=> (cnt_o == $past(cnt_o)));
    // R2: latch write lands in the counter
    a_r2_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
        latch_wr |=> (cnt_o == $past(latch_data)));
endmodule

// File: rtl/reload_timer.sv
module reload_timer
    import rt_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         src_clk,
    input  logic         evt_pin,
    input  logic         meas_pin,
    input  logic [1:0]   mode,
    input  logic         gate_en,
    input  logic         gate_level,
    input  logic         stop,
    input  logic         latch_wr,
    input  logic [W-1:0] latch_data,
    input  logic         out_en,
    input  logic         preset_wr,
    input  logic         preset_val,
    output logic [W-1:0] count,
    output logic         irq,
    output logic         tout
);
    rt_mode_e mode_e;
    logic     src_sel;
    logic     src_fall, src_rise;
    logic     meas_lvl;
    logic     cnt_en;
    logic     tout_q;

    assign mode_e  = rt_mode_e'(mode);
    assign src_sel = (mode_e == MODE_EVENT) ? evt_pin : src_clk;

    rt_edge #(.STAGES(SYNC_STAGES)) u_src_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (src_sel),
        .fall  (src_fall),
        .rise  (src_rise)
    );

    rt_sync #(.STAGES(SYNC_STAGES)) u_meas_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (meas_pin),
        .q     (meas_lvl)
    );

    assign cnt_en = ~gate_en | (meas_lvl == gate_level);

    rt_counter #(.W(W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall       (src_fall),
        .rise       (src_rise),
        .en         (cnt_en),
        .stop       (stop),
        .latch_wr   (latch_wr),
        .latch_data (latch_data),
        .cnt_o      (count),
        .irq_o      (irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       tout_q <= 1'b0;
        else if (preset_wr && stop)       tout_q <= preset_val;
        else if (irq && mode_e == MODE_PULSE) tout_q <= ~tout_q;
    end

    assign tout = out_en & tout_q;

    // R8: pulse mode flips the flop after each request
    a_r8_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && mode_e == MODE_PULSE && !(preset_wr && stop)) |=> (tout_q != $past(tout_q)));
    // R9: a running timer without overflow keeps the flop level
    a_r9_preset_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop && !irq) |=> $stable(tout_q));
endmodule

// File: tb/reload_timer_tb.sv
module reload_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 6;

    typedef struct {
        logic [7:0] cnt;
        int         irqs;
        logic       tout;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_clk = 1'b1, evt_pin = 1'b1, meas_pin = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       gate_en = 1'b0, gate_level = 1'b0, stop = 1'b1;
    logic       latch_wr = 1'b0;
    logic [7:0] latch_data = 8'h00;
    logic       out_en = 1'b1, preset_wr = 1'b0, preset_val = 1'b0;
    logic [7:0] count;
    logic       irq, tout;

    int   checks = 0, errors = 0, irq_seen = 0;
    bit   done = 1'b0;
    exp_t exp_q[$];
    event chk_ev;

    // reference model state
    logic [7:0] m_cnt = 8'hFF, m_latch = 8'hFF;
    bit         m_ovf = 1'b0, m_tq = 1'b0;
    int         m_irqs = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reload_timer u_dut (
        .clk(clk), .rst_n(rst_n), .src_clk(src_clk), .evt_pin(evt_pin),
        .meas_pin(meas_pin), .mode(mode), .gate_en(gate_en),
        .gate_level(gate_level), .stop(stop), .latch_wr(latch_wr),
        .latch_data(latch_data), .out_en(out_en), .preset_wr(preset_wr),
        .preset_val(preset_val), .count(count), .irq(irq), .tout(tout)
    );

    always @(negedge clk) if (rst_n && irq) irq_seen++;

    task automatic cmp_i(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor: pops expected items and compares with the ports
    initial begin
        forever begin
            @(chk_ev);
            while (exp_q.size() > 0) begin
                exp_t it;
                it = exp_q.pop_front();
                cmp_i(it.req, "count", int'(count), int'(it.cnt));
                cmp_i(it.req, "irqs", irq_seen, it.irqs);
                cmp_i(it.req, "tout", int'(tout), int'(it.tout));
            end
        end
    end

    task automatic expect_now(input string req);
        exp_t it;
        it.cnt  = m_cnt;
        it.irqs = m_irqs;
        it.tout = out_en ? m_tq : 1'b0;
        it.req  = req;
        exp_q.push_back(it);
        -> chk_ev;
        #1;
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    function automatic bit m_en();
        return !stop && (!gate_en || (meas_pin == gate_level));
    endfunction

    task automatic model_edge(input bit level);
        if (!m_en()) return;
        if (!level) begin
            if (m_cnt == 8'hFF) m_cnt = m_latch - 8'd1;
            else                m_cnt = m_cnt - 8'd1;
            m_ovf = 1'b0;
        end else if (m_cnt == 8'hFF && !m_ovf) begin
            m_ovf = 1'b1;
            m_irqs++;
            if (mode == 2'b10) m_tq = ~m_tq;
        end
    endtask

    // drive one pin level; which=1 selects evt_pin
    task automatic pin_set(input bit which, input bit level, input string req);
        bit sel;
        bit changed;
        @(negedge clk);
        sel = ((mode == 2'b01) == which);
        changed = which ? (evt_pin != level) : (src_clk != level);
        if (which) evt_pin = level; else src_clk = level;
        if (sel && changed) model_edge(level);
        settle();
        expect_now(req);
    endtask

    task automatic pulse_src(input bit which, input string req);
        pin_set(which, 1'b0, req);
        pin_set(which, 1'b1, req);
    endtask

    task automatic write_latch(input logic [7:0] v, input string req);
        @(negedge clk);
        latch_data = v; latch_wr = 1'b1;
        @(negedge clk);
        latch_wr = 1'b0;
        m_latch = v; m_cnt = v; m_ovf = 1'b0;
        settle();
        expect_now(req);
    endtask

    task automatic set_stop(input bit v);
        @(negedge clk);
        stop = v;
        if (!v) m_ovf = 1'b0;
        settle();
    endtask

    task automatic do_preset(input bit v, input string req);
        @(negedge clk);
        preset_val = v; preset_wr = 1'b1;
        if (stop) m_tq = v;
        @(negedge clk);
        preset_wr = 1'b0;
        settle();
        expect_now(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        expect_now("R1");

        // R3: edges while stopped do nothing
        pulse_src(1'b0, "R3");
        write_latch(8'h03, "R2");
        set_stop(1'b0);
        expect_now("R3");

        // R4 countdown 3 -> FF, R6 overflow, R5 reload
        pulse_src(1'b0, "R4");
        pulse_src(1'b0, "R4");
        pulse_src(1'b0, "R4");
        pin_set(1'b0, 1'b0, "R4");
        pin_set(1'b0, 1'b1, "R6");
        pin_set(1'b0, 1'b0, "R5");
        pin_set(1'b0, 1'b1, "R5");
        // R8: timer mode does not toggle (checked through tout=0 above)

        // R7: event pin ignored in timer mode
        pulse_src(1'b1, "R7");

        // R11: gate closed then open
        @(negedge clk); gate_en = 1'b1; gate_level = 1'b1; meas_pin = 1'b0;
        settle();
        pulse_src(1'b0, "R11");
        @(negedge clk); meas_pin = 1'b1;
        settle();
        pulse_src(1'b0, "R11");
        @(negedge clk); gate_en = 1'b0;
        settle();

        // R9: preset ignored while running
        do_preset(1'b1, "R9");

        // R2 collision: latch write meets a counted falling edge
        @(negedge clk); src_clk = 1'b0;
        @(negedge clk);
        @(negedge clk); latch_data = 8'h07; latch_wr = 1'b1;
        @(negedge clk); latch_wr = 1'b0;
        m_latch = 8'h07; m_cnt = 8'h07; m_ovf = 1'b0;
        settle();
        expect_now("R2");
        pin_set(1'b0, 1'b1, "R2");
        pin_set(1'b0, 1'b0, "R2");
        pin_set(1'b0, 1'b1, "R2");

        // R8 / R9 / R10: pulse mode with n=0
        set_stop(1'b1);
        do_preset(1'b1, "R9");
        write_latch(8'h00, "R5");
        @(negedge clk); mode = 2'b10;
        settle();
        set_stop(1'b0);
        for (int i = 0; i < 3; i++) pulse_src(1'b0, "R8");
        @(negedge clk); out_en = 1'b0;
        settle();
        expect_now("R10");
        pulse_src(1'b0, "R10");
        @(negedge clk); out_en = 1'b1;
        settle();
        expect_now("R10");

        // R7: event mode counts evt_pin only
        set_stop(1'b1);
        @(negedge clk); mode = 2'b01;
        settle();
        write_latch(8'h02, "R7");
        set_stop(1'b0);
        pulse_src(1'b0, "R7");
        pulse_src(1'b1, "R7");
        pulse_src(1'b1, "R7");

        // R3: stopping mid count freezes
        set_stop(1'b1);
        pulse_src(1'b1, "R3");
        set_stop(1'b0);
        pulse_src(1'b1, "R3");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule